// File: doc/BRIEF.md
# Seconds Prescaler Rate Trim

This block divides a reference clock of nominally 32768 Hz down to a one-second strobe. It nudges the rate of that strobe by stretching or shrinking one second per correction window. Software loads a trim setting through a one-cycle write strobe. The setting has three parts: a 6-bit adjust code, a subtract flag and a window-select flag.

The block counts seconds inside the current window. In the last second of the window it moves the prescaler terminal count up or down by twice the decoded step count. A written setting waits in a pending register and is raised to the active setting at the next window boundary. A busy flag covers the time from the write until that boundary. While the flag is high, software must not write again.

Top module: `rate_trim`

## Requirements
- R1: After reset, busy_o is low, sec_o is low, the active setting applies no correction and the short window is selected.
- R2: A second that is not the last of its window lasts exactly PRESCALE reference cycles. sec_o is high for one cycle, in the final cycle of each second.
- R3: The window is SHORT_WIN seconds when the active window flag is 0, and LONG_WIN seconds when it is 1. Only the last second of a window has its length changed.
- R4: With the subtract flag at 0 and an adjust code F of 2 to 63, the step count is F-1. The last second of the window is lengthened by 2*(F-1) cycles. A code of 1 gives zero steps.
- R5: With the subtract flag at 1 and a non-zero code F, the step count is the 6-bit inverse of F plus one (64-F). Code 63 gives 1 step, code 2 gives 62 steps and code 1 gives 63 steps. The last second is shortened by twice the step count.
- R6: An adjust code of 0 gives no correction in either direction.
- R7: busy_o rises in the cycle after a write. It stays high until the next window boundary, which is the final cycle of the last second of a window, and it is low from the cycle after that boundary.
- R8: A new setting, including its window flag, takes effect only for the window that starts after the boundary. The window that closes at that boundary still uses the previous setting, both for its length and for its correction.
- R9: A second write while busy_o is high replaces the pending setting. The last setting written is the one applied, and busy_o stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock; each cycle is one prescaler pulse |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | One-cycle write strobe for the trim setting |
| wr_adj_i | input | 6 | Adjust code |
| wr_sub_i | input | 1 | 1 = shorten the last second, 0 = lengthen it |
| wr_long_i | input | 1 | 1 = LONG_WIN window, 0 = SHORT_WIN window |
| sec_o | output | 1 | One-cycle pulse in the final cycle of each second |
| busy_o | output | 1 | High while a written setting waits for a window boundary |

## Verification
The bench builds the block with PRESCALE = 200, SHORT_WIN = 2 and LONG_WIN = 3. With these values a window closes within a few hundred cycles, so many windows and setting changes fit in one short run. A terminal count of 200 still leaves room for the largest shortening of 126 cycles. This makes every adjust code reachable, including the extreme step counts in both directions. It also lets the bench switch between window lengths often enough to check the boundary rules of R8 and R9 many times.

// File: rtl/rate_trim_pkg.sv
package rate_trim_pkg;
  localparam int ADJ_W  = 6;
  localparam int STEP_W = ADJ_W + 1;
  localparam int PULS_W = STEP_W + 1;

  typedef struct packed {
    logic             sub;
    logic             long_win;
    logic [ADJ_W-1:0] adj;
  } trim_cfg_t;

  // code 0: none; add: F-1; subtract: ~F + 1 over ADJ_W bits
  function automatic logic [STEP_W-1:0] trim_steps(trim_cfg_t c);
    logic [STEP_W-1:0] f;
    f = {1'b0, c.adj};
    if (c.adj == '0) return '0;
    if (!c.sub) return f - STEP_W'(1);
    return {1'b0, ~c.adj} + STEP_W'(1);
  endfunction
endpackage

// File: rtl/rate_trim_decode.sv
module rate_trim_decode
  import rate_trim_pkg::*;
(
  input  trim_cfg_t          cfg_i,
  output logic [STEP_W-1:0]  steps_o,
  output logic [PULS_W-1:0]  pulses_o
);
  always_comb begin
    steps_o  = trim_steps(cfg_i);
    pulses_o = {steps_o, 1'b0};
  end

  always_comb begin
    if (cfg_i.adj == '0) begin
      AST_ZERO_NO_STEP: assert (pulses_o == '0); // R6
    end
    if (cfg_i.sub && cfg_i.adj != '0) begin
      AST_SUB_NONZERO: assert (steps_o != '0); // R5
    end
  end
endmodule

// File: rtl/rate_trim_prescaler.sv
module rate_trim_prescaler
  import rate_trim_pkg::*;
#(
  parameter int PRESCALE = 32768  // must exceed 2*64 + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trim_i,
  input  logic              sub_i,
  input  logic [PULS_W-1:0] pulses_i,
  output logic              sec_o
);
  localparam int CNT_W = $clog2(PRESCALE + (1 << PULS_W) + 1);

  logic [CNT_W-1:0] cnt_q, term;

  always_comb begin
    term = CNT_W'(PRESCALE);
    if (trim_i) term = sub_i ? term - CNT_W'(pulses_i) : term + CNT_W'(pulses_i);
    sec_o = (cnt_q == term - CNT_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (sec_o) cnt_q <= '0;
    else            cnt_q <= cnt_q + CNT_W'(1);
  end

  AST_SEC_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_o |=> !sec_o); // R2
  AST_CNT_BELOW_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < term); // R2
endmodule

// File: rtl/rate_trim_window.sv
module rate_trim_window #(
  parameter int SHORT_WIN = 20,
  parameter int LONG_WIN  = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sec_i,
  input  logic long_i,
  output logic last_o,
  output logic bound_o
);
  localparam int MAX_WIN = (LONG_WIN > SHORT_WIN) ? LONG_WIN : SHORT_WIN;
  localparam int IDX_W   = $clog2(MAX_WIN + 1);

  logic [IDX_W-1:0] idx_q, len;

  always_comb begin
    len     = long_i ? IDX_W'(LONG_WIN) : IDX_W'(SHORT_WIN);
    last_o  = (idx_q == len - IDX_W'(1));
    bound_o = sec_i & last_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (bound_o) idx_q <= '0;
    else if (sec_i)   idx_q <= idx_q + IDX_W'(1);
  end

  AST_IDX_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q < len); // R3
  AST_BOUND_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bound_o |=> idx_q == '0); // R3
endmodule

// File: rtl/rate_trim_shadow.sv
module rate_trim_shadow
  import rate_trim_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_en_i,
  input  trim_cfg_t wr_cfg_i,
  input  logic      bound_i,
  output trim_cfg_t cur_o,
  output logic      busy_o
);
  trim_cfg_t pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      cur_o  <= '0;
      busy_o <= 1'b0;
    end else begin
      if (wr_en_i) pend_q <= wr_cfg_i;
      if (bound_i && busy_o) cur_o <= pend_q;
      if (wr_en_i)      busy_o <= 1'b1;
      else if (bound_i) busy_o <= 1'b0;
    end
  end

  AST_BUSY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> busy_o); // R7
  AST_BUSY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !bound_i |=> busy_o); // R7
  AST_BUSY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bound_i && !wr_en_i |=> !busy_o); // R7
  AST_CUR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bound_i |=> $stable(cur_o)); // R8
endmodule

// File: rtl/rate_trim.sv
module rate_trim
  import rate_trim_pkg::*;
#(
  parameter int PRESCALE  = 32768,
  parameter int SHORT_WIN = 20,
  parameter int LONG_WIN  = 60
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [ADJ_W-1:0] wr_adj_i,
  input  logic             wr_sub_i,
  input  logic             wr_long_i,
  output logic             sec_o,
  output logic             busy_o
);
  trim_cfg_t         wr_cfg, cur_cfg;
  logic [STEP_W-1:0] steps;
  logic [PULS_W-1:0] pulses;
  logic              win_last, win_bound;

  assign wr_cfg = '{sub: wr_sub_i, long_win: wr_long_i, adj: wr_adj_i};

  rate_trim_shadow u_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_cfg_i (wr_cfg),
    .bound_i  (win_bound),
    .cur_o    (cur_cfg),
    .busy_o   (busy_o)
  );

  rate_trim_decode u_decode (
    .cfg_i    (cur_cfg),
    .steps_o  (steps),
    .pulses_o (pulses)
  );

  rate_trim_window #(
    .SHORT_WIN (SHORT_WIN),
    .LONG_WIN  (LONG_WIN)
  ) u_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sec_i   (sec_o),
    .long_i  (cur_cfg.long_win),
    .last_o  (win_last),
    .bound_o (win_bound)
  );

  rate_trim_prescaler #(
    .PRESCALE (PRESCALE)
  ) u_prescaler (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trim_i   (win_last),
    .sub_i    (cur_cfg.sub),
    .pulses_i (pulses),
    .sec_o    (sec_o)
  );

  AST_STEP_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steps <= STEP_W'(63)); // R5
endmodule

// File: tb/rate_trim_tb.sv
`timescale 1ns/1ps
module rate_trim_tb;
  localparam int PRE = 200;
  localparam int SW  = 2;
  localparam int LW  = 3;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [5:0] wr_adj = '0;
  logic       wr_sub = 1'b0;
  logic       wr_long = 1'b0;
  logic       sec_o, busy_o;

  int checks = 0, fails = 0;
  int cyc = 0, last_end = -1, m_pos = 0;
  bit last_sec = 1'b0, m_busy = 1'b0;
  bit m_sub = 0, m_long = 0, p_sub = 0, p_long = 0;
  bit [5:0] m_adj = '0, p_adj = '0;

  always #2 clk = ~clk;

  rate_trim #(.PRESCALE(PRE), .SHORT_WIN(SW), .LONG_WIN(LW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_adj_i(wr_adj),
    .wr_sub_i(wr_sub), .wr_long_i(wr_long), .sec_o(sec_o), .busy_o(busy_o)
  );

  function automatic int exp_len(bit sub, bit [5:0] adj, bit last);
    int s;
    if (!last) return PRE;
    if (adj == 0)  s = 0;
    else if (!sub) s = int'(adj) - 1;
    else           s = 64 - int'(adj);
    return sub ? PRE - 2 * s : PRE + 2 * s;
  endfunction

  function automatic int win_of(bit lng);
    return lng ? LW : SW;
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic step();
    int  len;
    bit  last;
    @(negedge clk);
    wr_en = 1'b0;
    cyc++;
    chk(busy_o == m_busy, "R7 busy", int'(busy_o), int'(m_busy));
    if (sec_o) begin
      len  = cyc - last_end;
      last = (m_pos == win_of(m_long) - 1);
      if (!last)          chk(len == PRE, "R2 plain second", len, PRE);
      else if (m_adj == 0) chk(len == PRE, "R6 R3 R8 zero code", len, PRE);
      else if (m_sub)     chk(len == exp_len(m_sub, m_adj, 1'b1), "R5 R3 R8 subtract",
                              len, exp_len(m_sub, m_adj, 1'b1));
      else                chk(len == exp_len(m_sub, m_adj, 1'b1), "R4 R3 R8 add",
                              len, exp_len(m_sub, m_adj, 1'b1));
      last_end = cyc;
      if (last) begin
        m_pos = 0;
        if (m_busy) begin
          m_sub = p_sub; m_long = p_long; m_adj = p_adj;
          m_busy = 1'b0;
        end
      end else begin
        m_pos++;
      end
    end
    last_sec = sec_o;
  endtask

  task automatic write_cfg(bit sub, bit [5:0] adj, bit lng);
    while (last_sec) step();
    wr_en = 1'b1; wr_sub = sub; wr_adj = adj; wr_long = lng;
    p_sub = sub; p_adj = adj; p_long = lng;
    m_busy = 1'b1;
    step();
  endtask

  task automatic run_secs(int n);
    int seen = 0;
    while (seen < n) begin
      step();
      if (last_sec) seen++;
    end
  endtask

  task automatic settle_and_observe();
    while (m_busy) step();
    run_secs(LW + 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    chk(busy_o == 1'b0, "R1 busy after reset", int'(busy_o), 0);
    chk(sec_o == 1'b0, "R1 sec after reset", int'(sec_o), 0);
    run_secs(2 * SW + 1); // R1: short window, no correction

    // directed decode corners
    write_cfg(1'b0, 6'd2, 1'b0);  settle_and_observe(); // R4 one step
    write_cfg(1'b0, 6'd63, 1'b1); settle_and_observe(); // R4 62 steps, long
    write_cfg(1'b0, 6'd1, 1'b0);  settle_and_observe(); // R4 zero steps
    write_cfg(1'b1, 6'd63, 1'b0); settle_and_observe(); // R5 one step
    write_cfg(1'b1, 6'd2, 1'b1);  settle_and_observe(); // R5 62 steps
    write_cfg(1'b1, 6'd1, 1'b0);  settle_and_observe(); // R5 63 steps
    write_cfg(1'b1, 6'd0, 1'b1);  settle_and_observe(); // R6
    write_cfg(1'b0, 6'd0, 1'b0);  settle_and_observe(); // R6

    // R9: overwrite while busy
    write_cfg(1'b0, 6'd40, 1'b1);
    write_cfg(1'b1, 6'd10, 1'b0);
    chk(busy_o == 1'b1, "R9 busy held", int'(busy_o), 1);
    settle_and_observe();

    for (int i = 0; i < 30; i++) begin
      bit [5:0] a = 6'($urandom);
      bit       s = 1'($urandom);
      bit       l = 1'($urandom);
      write_cfg(s, a, l);
      if (($urandom % 4) == 0) begin
        repeat (int'($urandom % 50)) step();
        if (m_busy) write_cfg(1'($urandom), 6'($urandom), 1'($urandom)); // R9
      end
      while (m_busy) step();
      run_secs(int'($urandom % 5) + 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule